// File: doc/BRIEF.md
# Quad DAC command serialiser

This block turns one DAC command into a serial frame on a four-wire serial bus in SPI mode 0. A frame carries a 4-bit command, a 4-bit channel address and a 12-bit sample code. The caller raises `load_i` for one cycle while `busy_o` is low. The block captures the command, address and code in that cycle. It then drives chip select low, shifts the frame out MSB first and raises chip select again. The converter acts on the command only when chip select rises.

A long frame is 32 bits and starts with an all-zero pad byte. A short frame is 24 bits and has no pad byte. The caller picks the frame type with `short_frame_i`, which is sampled together with `load_i`. The serial clock is divided from the system clock by the parameter `HALF_CYC`. A separate clear request drives an active-low clear line to the converter, and this line works independently of any transfer. The serial data line coming back from the converter is not used.

Top module: `dac_cmd_serializer`

## Requirements
- R1: While `rst_n` is low, `cs_n_o` is 1, `sclk_o` is 0, `mosi_o` is 0, `busy_o` is 0 and `clr_n_o` is 0.
- R2: A load with `short_frame_i`=0 sends exactly 32 bits while `cs_n_o` is low. Bit order on the wire: eight 0 bits, then `cmd_i[3:0]`, then `addr_i[3:0]`, then `code_i[11:0]`, then four 0 bits, each field MSB first.
- R3: A load with `short_frame_i`=1 sends exactly 24 bits: `cmd_i[3:0]`, `addr_i[3:0]`, `code_i[11:0]` and four 0 bits, with no leading pad byte.
- R4: `mosi_o` changes only in the cycle where `sclk_o` falls, or in the cycle where `cs_n_o` falls. While `sclk_o` is 1, `mosi_o` holds its value.
- R5: `sclk_o` is 0 whenever `cs_n_o` is 1. Inside a frame, consecutive rising edges of `sclk_o` are exactly 2*`HALF_CYC` system cycles apart. The first rise comes `HALF_CYC` cycles after `cs_n_o` falls.
- R6: `cs_n_o` rises after the falling `sclk_o` edge that follows the last bit. It then stays high for at least 2*`HALF_CYC` cycles before the next frame starts.
- R7: When a load is accepted, `busy_o` is 1 from the next cycle until the gap after chip select has ended. `busy_o` is 1 whenever `cs_n_o` is 0. A load raised while `busy_o` is 1 is ignored and starts no frame.
- R8: `clr_n_o` is 0 in the cycle after `clear_i` is 1 and 1 in the cycle after `clear_i` is 0. A clear neither disturbs nor delays a frame in progress.
- R9: A frame carries the field values captured in its load cycle. Changes to `cmd_i`, `addr_i`, `code_i` or `short_frame_i` during the transfer do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start request, taken when busy_o is low |
| short_frame_i | input | 1 | 1 selects the 24-bit frame, 0 the 32-bit frame |
| cmd_i | input | 4 | Command nibble |
| addr_i | input | 4 | Channel address nibble (4'b1111 = all channels) |
| code_i | input | 12 | Unsigned sample code |
| clear_i | input | 1 | Request to hold the converter in clear |
| busy_o | output | 1 | Transfer or inter-frame gap in progress |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the converter |
| cs_n_o | output | 1 | Active-low chip select |
| clr_n_o | output | 1 | Active-low clear to the converter |

## Verification
The hardest case to create from the ports is a second load that arrives while a frame is still on the wire, with the field inputs changing at the same moment. The bench starts a frame and waits partway into the shifting. It then changes every field input and pulses the load again. It checks that the wire still carries the first frame and that no further chip-select cycle follows. The same frame receives a clear pulse in its middle, to show that the clear line runs independently. Sweeps over all command and address pairs and a spread of sample codes, in both frame lengths, cover the field placement.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } dacw_state_e;

    localparam int PAD_BYTE_W = 8;
    localparam int DATA_FIELD_W = 16;

    localparam logic [3:0] CMD_WRITE_UPDATE = 4'b0011;
    localparam logic [3:0] ADDR_ALL_CHANNELS = 4'b1111;

endpackage

// File: rtl/dacw_tick_gen.sv
module dacw_tick_gen #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run_i && (cnt_q != LAST)) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/dacw_frame_pack.sv
module dacw_frame_pack
    import dacw_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int CMD_W  = 4,
    parameter int ADDR_W = 4
) (
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              short_i,
    output logic [CMD_W+ADDR_W+DATA_FIELD_W+PAD_BYTE_W-1:0] frame_o,
    output logic [$clog2(CMD_W+ADDR_W+DATA_FIELD_W+PAD_BYTE_W+1)-1:0] nbits_o
);
    localparam int PAD_W  = DATA_FIELD_W - CODE_W;
    localparam int WORD_W = CMD_W + ADDR_W + DATA_FIELD_W;
    localparam int LONG_W = WORD_W + PAD_BYTE_W;
    localparam int NB_W   = $clog2(LONG_W + 1);

    logic [DATA_FIELD_W-1:0] field;
    logic [WORD_W-1:0]       word;

    generate
        if (PAD_W > 0) begin : g_pad
            assign field = {code_i, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign field = code_i[CODE_W-1 -: DATA_FIELD_W];
        end
    endgenerate

    assign word = {cmd_i, addr_i, field};

    always_comb begin
        if (short_i) begin
            frame_o = {word, {PAD_BYTE_W{1'b0}}};
            nbits_o = NB_W'(WORD_W);
        end else begin
            frame_o = {{PAD_BYTE_W{1'b0}}, word};
            nbits_o = NB_W'(LONG_W);
        end
    end

endmodule

// File: rtl/dacw_shift_core.sv
module dacw_shift_core
    import dacw_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int NB_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [NB_W-1:0]    nbits_i,
    output logic               run_o,
    output logic               sclk_o,
    output logic               mosi_o,
    output logic               cs_n_o,
    output logic               busy_o
);
    typedef struct packed {
        dacw_state_e        state;
        logic [FRAME_W-1:0] sr;
        logic [NB_W-1:0]    left;
        logic               sclk;
        logic               mosi;
        logic               cs_n;
        logic               busy;
        logic               gap;
    } core_t;

    localparam core_t CORE_RST = '{
        state: ST_IDLE, sr: '0, left: '0, sclk: 1'b0,
        mosi: 1'b0, cs_n: 1'b1, busy: 1'b0, gap: 1'b0
    };

    core_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (load_i) begin
                    r_d.state = ST_SHIFT;
                    r_d.mosi  = frame_i[FRAME_W-1];
                    r_d.sr    = frame_i << 1;
                    r_d.left  = nbits_i;
                    r_d.cs_n  = 1'b0;
                    r_d.sclk  = 1'b0;
                    r_d.busy  = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (tick_i) begin
                    if (!r_q.sclk) begin
                        r_d.sclk = 1'b1;
                    end else begin
                        r_d.sclk = 1'b0;
                        r_d.left = r_q.left - NB_W'(1);
                        if (r_q.left == NB_W'(1)) begin
                            r_d.cs_n  = 1'b1;
                            r_d.mosi  = 1'b0;
                            r_d.gap   = 1'b0;
                            r_d.state = ST_GAP;
                        end else begin
                            r_d.mosi = r_q.sr[FRAME_W-1];
                            r_d.sr   = r_q.sr << 1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick_i) begin
                    if (r_q.gap) begin
                        r_d.state = ST_IDLE;
                        r_d.busy  = 1'b0;
                    end else begin
                        r_d.gap = 1'b1;
                    end
                end
            end
            default: begin
                r_d = CORE_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= CORE_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign run_o  = (r_q.state != ST_IDLE);
    assign sclk_o = r_q.sclk;
    assign mosi_o = r_q.mosi;
    assign cs_n_o = r_q.cs_n;
    assign busy_o = r_q.busy;

endmodule

// File: rtl/dac_cmd_serializer.sv
module dac_cmd_serializer
    import dacw_pkg::*;
#(
    parameter int HALF_CYC = 4,
    parameter int CODE_W   = 12,
    parameter int CMD_W    = 4,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              short_frame_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              clear_i,
    output logic              busy_o,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              cs_n_o,
    output logic              clr_n_o
);
    localparam int WORD_W = CMD_W + ADDR_W + DATA_FIELD_W;
    localparam int LONG_W = WORD_W + PAD_BYTE_W;
    localparam int NB_W   = $clog2(LONG_W + 1);

    logic [LONG_W-1:0] frame;
    logic [NB_W-1:0]   nbits;
    logic              tick;
    logic              run;
    logic              clr_n_d, clr_n_q;

    dacw_frame_pack #(
        .CODE_W (CODE_W),
        .CMD_W  (CMD_W),
        .ADDR_W (ADDR_W)
    ) u_pack (
        .cmd_i   (cmd_i),
        .addr_i  (addr_i),
        .code_i  (code_i),
        .short_i (short_frame_i),
        .frame_o (frame),
        .nbits_o (nbits)
    );

    dacw_tick_gen #(
        .HALF_CYC (HALF_CYC)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    dacw_shift_core #(
        .FRAME_W (LONG_W),
        .NB_W    (NB_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .load_i  (load_i),
        .frame_i (frame),
        .nbits_i (nbits),
        .run_o   (run),
        .sclk_o  (sclk_o),
        .mosi_o  (mosi_o),
        .cs_n_o  (cs_n_o),
        .busy_o  (busy_o)
    );

    always_comb begin
        clr_n_d = !clear_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_n_q <= 1'b0;
        end else begin
            clr_n_q <= clr_n_d;
        end
    end

    assign clr_n_o = clr_n_q;

endmodule

// File: rtl/dacw_chk.sv
module dacw_chk #(
    parameter int HALF_CYC   = 4,
    parameter int LONG_BITS  = 32,
    parameter int SHORT_BITS = 24
) (
    input logic clk,
    input logic rst_n,
    input logic load_i,
    input logic clear_i,
    input logic busy_o,
    input logic sclk_o,
    input logic mosi_o,
    input logic cs_n_o,
    input logic clr_n_o
);
    logic [15:0] high_cnt;
    logic [7:0]  rise_cnt;
    logic        sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_cnt  <= 16'hFFFF;
            rise_cnt  <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk_o;
            if (cs_n_o) begin
                if (high_cnt != 16'hFFFF) high_cnt <= high_cnt + 16'd1;
            end else begin
                high_cnt <= '0;
            end
            if (cs_n_o) begin
                rise_cnt <= '0;
            end else if (sclk_o && !sclk_prev) begin
                rise_cnt <= rise_cnt + 8'd1;
            end
        end
    end

    // R5
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(mosi_o));

    // R7
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);

    // R7
    start_needs_idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> $past(load_i && !busy_o));

    // R6
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (32'(high_cnt) >= 32'(2 * HALF_CYC)));

    // R2
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (32'(rise_cnt) == LONG_BITS || 32'(rise_cnt) == SHORT_BITS));

    // R8
    clear_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear_i) |-> !clr_n_o);

endmodule

bind dac_cmd_serializer dacw_chk #(
    .HALF_CYC   (HALF_CYC),
    .LONG_BITS  (LONG_W),
    .SHORT_BITS (WORD_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .clear_i (clear_i),
    .busy_o  (busy_o),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .cs_n_o  (cs_n_o),
    .clr_n_o (clr_n_o)
);

// File: tb/sim_dac_cmd_serializer.sv
`timescale 1ns/1ps
module sim_dac_cmd_serializer;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic        short_frame_i = 1'b0;
    logic [3:0]  cmd_i = '0;
    logic [3:0]  addr_i = '0;
    logic [11:0] code_i = '0;
    logic        clear_i = 1'b0;
    logic        busy_o, sclk_o, mosi_o, cs_n_o, clr_n_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dac_cmd_serializer #(.HALF_CYC(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .short_frame_i(short_frame_i),
        .cmd_i(cmd_i), .addr_i(addr_i), .code_i(code_i), .clear_i(clear_i),
        .busy_o(busy_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o),
        .clr_n_o(clr_n_o)
    );

    // wire monitor, sampled at the falling system clock edge
    int          cyc = 0;
    logic [31:0] cap = '0;
    int          nbit = 0;
    int          frames = 0;
    int          last_rise = -1;
    int          cs_rise_cyc = -1000;
    int          first_gap = -1;
    int          period_err = 0;
    int          first_err = 0;
    int          mosi_err = 0;
    int          idle_err = 0;
    int          gap_err = 0;
    int          cs_fall_cyc = 0;
    logic        p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc = cyc + 1;
            if (p_cs && !cs_n_o) begin
                cap = '0; nbit = 0; last_rise = -1; frames = frames + 1;
                cs_fall_cyc = cyc;
                if (cyc - cs_rise_cyc < 2 * HALF) gap_err = gap_err + 1;
            end
            if (!p_cs && cs_n_o) cs_rise_cyc = cyc;
            if (!cs_n_o && sclk_o && !p_sclk) begin
                cap = {cap[30:0], mosi_o};
                if (nbit == 0 && (cyc - cs_fall_cyc) != HALF) first_err = first_err + 1;
                nbit = nbit + 1;
                if (last_rise >= 0 && (cyc - last_rise) != 2 * HALF) period_err = period_err + 1;
                last_rise = cyc;
            end
            if (sclk_o && mosi_o != p_mosi) mosi_err = mosi_err + 1;
            if (cs_n_o && sclk_o) idle_err = idle_err + 1;
        end
        p_sclk = sclk_o; p_cs = cs_n_o; p_mosi = mosi_o;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic start_frame(input logic [3:0] c, input logic [3:0] a,
                               input logic [11:0] d, input logic s);
        while (busy_o) @(negedge clk);
        cmd_i = c; addr_i = a; code_i = d; short_frame_i = s; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        check(busy_o == 1'b1 && cs_n_o == 1'b0, "R7", "busy/cs after load",
              {busy_o, cs_n_o}, 2'b10);
    endtask

    task automatic end_frame(input logic [3:0] c, input logic [3:0] a,
                             input logic [11:0] d, input logic s);
        logic [31:0] exp;
        while (busy_o) @(negedge clk);
        if (s) begin
            exp = {8'h00, c, a, d, 4'h0};
            check(nbit == 24, "R3", "short bit count", nbit, 24);
            check(cap[23:0] == exp[23:0], "R3", "short frame", cap[23:0], exp[23:0]);
        end else begin
            exp = {8'h00, c, a, d, 4'h0};
            check(nbit == 32, "R2", "long bit count", nbit, 32);
            check(cap == exp, "R2", "long frame", cap, exp);
        end
    endtask

    task automatic send(input logic [3:0] c, input logic [3:0] a,
                        input logic [11:0] d, input logic s);
        start_frame(c, a, d, s);
        end_frame(c, a, d, s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails = fails + 1;
        checks = checks + 1;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int fr;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cs_n_o == 1 && sclk_o == 0 && mosi_o == 0 && busy_o == 0 && clr_n_o == 0,
              "R1", "reset outputs", {cs_n_o, sclk_o, mosi_o, busy_o, clr_n_o}, 5'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(clr_n_o == 1'b1, "R8", "clear idle high", clr_n_o, 1);

        // R2 default write-and-update to all channels
        send(4'b0011, 4'b1111, 12'h800, 1'b0);

        // R2 every command/address pair
        for (int c = 0; c < 16; c++) begin
            for (int a = 0; a < 16; a++) begin
                send(4'(c), 4'(a), 12'((c * 256 + a * 16 + c) ^ 12'hA5A), 1'b0);
            end
        end

        // R2 code sweep including both ends
        send(4'h3, 4'h0, 12'h000, 1'b0);
        send(4'h3, 4'h1, 12'hFFF, 1'b0);
        for (int k = 0; k < 132; k++) begin
            send(4'h3, 4'(k), 12'(k * 31), 1'b0);
        end

        // R3 short frames, interleaved with long frames
        for (int k = 0; k < 40; k++) begin
            send(4'(k * 7), 4'(k), 12'(k * 103 + 1), 1'b1);
            if (k % 8 == 0) send(4'(k), 4'hF, 12'(~(k * 9)), 1'b0);
        end
        send(4'hF, 4'hF, 12'hFFF, 1'b1);
        send(4'h0, 4'h0, 12'h000, 1'b1);

        // R7 / R9 load and field changes mid-frame, R8 clear mid-frame
        fr = frames;
        start_frame(4'h3, 4'h2, 12'h5A3, 1'b0);
        repeat (10 * HALF) @(negedge clk);
        cmd_i = 4'hC; addr_i = 4'h9; code_i = 12'h0F0; short_frame_i = 1'b1;
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        clear_i = 1'b1;
        @(negedge clk);
        check(clr_n_o == 1'b0, "R8", "clear low after request", clr_n_o, 0);
        check(busy_o == 1'b1 && cs_n_o == 1'b0, "R8", "frame continues under clear",
              {busy_o, cs_n_o}, 2'b10);
        clear_i = 1'b0;
        @(negedge clk);
        check(clr_n_o == 1'b1, "R8", "clear released", clr_n_o, 1);
        end_frame(4'h3, 4'h2, 12'h5A3, 1'b0);
        repeat (20) @(negedge clk);
        check(frames == fr + 1, "R7", "ignored load starts no frame", frames - fr, 1);
        check(cs_n_o == 1'b1 && busy_o == 1'b0, "R9", "idle after frame",
              {cs_n_o, busy_o}, 2'b10);

        // R6 back-to-back frames
        for (int k = 0; k < 6; k++) send(4'h3, 4'hF, 12'(k * 700), 1'(k % 2));

        // global wire-timing checks
        check(mosi_err == 0, "R4", "data change while clock high", mosi_err, 0);
        check(period_err == 0, "R5", "serial clock period", period_err, 0);
        check(first_err == 0, "R5", "first rise offset", first_err, 0);
        check(idle_err == 0, "R5", "clock high with select high", idle_err, 0);
        check(gap_err == 0, "R6", "select high gap", gap_err, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule